// File: doc/BRIEF.md
# Partitioned Lockable Cache Controller

This block is a small set-associative cache controller whose timing is meant to be analysed, not just fast on average. Every core request carries a class-of-service number. A per-class way mask limits which ways a miss from that class may fill. Individual lines can be pinned so that no miss ever evicts them. Within the ways that are both permitted and unpinned, the victim is the next way in first-in-first-out order. Lookups from any class may hit in any way, so pinned or foreign lines can still be read by everyone.

The core side uses a valid/ready request channel with read/write select, word address, write data and class number, and a one-cycle response pulse. The memory side is a line refill channel: the controller holds one request until the memory returns a response pulse. Each line is one data word. Writes go straight through to memory, and a write miss allocates nothing. The mask registers and the pin/unpin command port are written directly. A read hit answers in the cycle after acceptance. A miss answers one cycle after the memory response.

Top module: `pcache_top`

## Requirements
- R1: A read that hits raises `rsp_valid` with the stored word in the cycle right after the request is accepted, and issues no memory request. `req_ready` is low from acceptance until the response has been given.
- R2: A read miss raises `mem_req_valid` with the request address in the cycle after lookup. `rsp_valid` pulses for one cycle, carrying `mem_rsp_rdata`, in the cycle after the clock edge that samples `mem_rsp_valid`. The line is then resident, so a repeat read hits.
- R3: The mask register for a class (bit w set = way w permitted) limits that class's fills to permitted ways. Fills by one class never evict a line held in a way that the class is not permitted to fill.
- R4: A read from any class hits on a resident line, whichever class filled it.
- R5: Within one set, each class fills its permitted, unpinned ways in first-in-first-out order. Hits do not change that order. The pointer for the set and class moves to the way after the one filled.
- R6: A pinned line is never chosen as a victim. A pin or unpin command (set index, way number, on/off) takes effect from the next clock edge. An unpinned line becomes eligible again.
- R7: If a class has no permitted, unpinned way in the indexed set, a read miss is served from memory with normal miss timing and allocates nothing.
- R8: Every write is sent to memory with its address and data, and responds one cycle after the memory response. A write hit also updates the cached word. A write miss allocates nothing.
- R9: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, all lines are invalid and unpinned, every FIFO pointer is 0, and every class mask permits all ways.
- R10: While `mem_req_valid` is high and no response has arrived, the memory address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low SET_W bits select the set |
| req_wdata | input | DATA_W | Write data |
| req_class | input | CLS_W | Class of service of the request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |
| mem_req_valid | output | 1 | Memory request held until response |
| mem_req_write | output | 1 | Memory request direction |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory response pulse |
| mem_rsp_rdata | input | DATA_W | Refill data |
| cfg_mask_we | input | 1 | Write a class way mask |
| cfg_mask_class | input | CLS_W | Class whose mask is written |
| cfg_mask_ways | input | WAYS | New way mask |
| cfg_lock_we | input | 1 | Pin/unpin command strobe |
| cfg_lock_set | input | SET_W | Set of the line to pin or unpin |
| cfg_lock_way | input | WAY_W | Way of the line to pin or unpin |
| cfg_lock_on | input | 1 | 1 = pin, 0 = unpin |

## Verification
The hardest state to reach is a set where the FIFO pointer sits on a pinned way. The victim must then skip forward, and after an unpin the same way must come back into rotation. The stimulus fills a fresh set in order, pins the first way, and issues enough distinct misses to wrap the pointer twice. It checks at the ports that the pinned address still hits. It then unpins the way and counts misses until that address is evicted. The empty-eligible-set bypass case comes from narrowing one class to a single way and pinning exactly that way, then reading the same address twice and seeing two memory transactions.

// File: rtl/pcache_pkg.sv
// Shared types for the partitioned cache controller.
package pcache_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOKUP,
        S_MEM,
        S_RESP
    } pc_state_e;

endpackage

// File: rtl/pcache_cfg.sv
// Per-class way mask registers.
// Assumes: one write port, one combinational read port; reset permits all ways.
module pcache_cfg #(
    parameter int WAYS    = 4,
    parameter int CLASSES = 4,
    parameter int CLS_W   = $clog2(CLASSES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CLS_W-1:0] wr_cls,
    input  logic [WAYS-1:0]  wr_mask,
    input  logic [CLS_W-1:0] rd_cls,
    output logic [WAYS-1:0]  rd_mask
);

    logic [WAYS-1:0] mask_q [CLASSES];

    // Hold the masks; reset opens every way to every class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CLASSES; c++) begin
                mask_q[c] <= '1;
            end
        end else if (we) begin
            mask_q[wr_cls] <= wr_mask;
        end
    end

    // Mask of the class currently being served.
    assign rd_mask = mask_q[rd_cls];

endmodule

// File: rtl/pcache_tag_store.sv
// Tag, data, valid and pin arrays with a parallel way compare.
// Assumes: fills and updates target the set being looked up; pin commands
// may target any set and are applied at the clock edge that samples them.
module pcache_tag_store #(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    parameter int SET_W  = $clog2(SETS),
    parameter int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    output logic [DATA_W-1:0] lk_data,
    output logic [WAYS-1:0]   lk_lock,
    input  logic              fill_en,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              lock_we,
    input  logic [SET_W-1:0]  lock_set,
    input  logic [WAY_W-1:0]  lock_way,
    input  logic              lock_val
);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   lock_q  [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   match;

    // Valid and pin state: cleared by reset, set by fills and commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
            end
        end else begin
            if (fill_en) begin
                valid_q[lk_set][fill_way] <= 1'b1;
            end
            if (lock_we) begin
                lock_q[lock_set][lock_way] <= lock_val;
            end
        end
    end

    // Tag and data payload; meaningless while the valid bit is clear.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[lk_set][fill_way]  <= fill_tag;
            data_q[lk_set][fill_way] <= fill_data;
        end else if (upd_en) begin
            data_q[lk_set][upd_way] <= upd_data;
        end
    end

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    // Encode the matching way and select its word.
    always_comb begin
        lk_way  = '0;
        lk_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                lk_way  = WAY_W'(w);
                lk_data = data_q[lk_set][w];
            end
        end
    end

    assign lk_hit  = |match;
    assign lk_lock = lock_q[lk_set];

endmodule

// File: rtl/pcache_victim.sv
// FIFO victim choice, one pointer per (set, class).
// Assumes: WAYS is a power of two so the pointer wraps by overflow.
module pcache_victim #(
    parameter int SETS    = 4,
    parameter int WAYS    = 4,
    parameter int CLASSES = 4,
    parameter int SET_W   = $clog2(SETS),
    parameter int WAY_W   = $clog2(WAYS),
    parameter int CLS_W   = $clog2(CLASSES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic [WAYS-1:0]  allowed_i,
    input  logic             adv_i,
    output logic [WAY_W-1:0] vic_way_o,
    output logic             vic_ok_o
);

    localparam int NPTR = SETS * CLASSES;

    logic [WAY_W-1:0]       ptr_q [NPTR];
    logic [SET_W+CLS_W-1:0] idx;
    logic [WAY_W-1:0]       cur;

    assign idx = {set_i, cls_i};
    assign cur = ptr_q[idx];

    // Circular search from the pointer for the first eligible way.
    always_comb begin
        logic [WAY_W-1:0] cand;
        vic_ok_o  = 1'b0;
        vic_way_o = '0;
        for (int k = 0; k < WAYS; k++) begin
            cand = cur + WAY_W'(k);
            if (!vic_ok_o && allowed_i[cand]) begin
                vic_ok_o  = 1'b1;
                vic_way_o = cand;
            end
        end
    end

    // Move the pointer past the way just filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPTR; p++) begin
                ptr_q[p] <= '0;
            end
        end else if (adv_i) begin
            ptr_q[idx] <= vic_way_o + WAY_W'(1);
        end
    end

endmodule

// File: rtl/pcache_top.sv
// Partitioned, pinnable, write-through cache controller.
// Assumes: one outstanding request; one word per line; memory holds off its
// response until mem_req_valid is seen and pulses mem_rsp_valid once.
module pcache_top #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int WAYS    = 4,
    parameter int SETS    = 4,
    parameter int CLASSES = 4,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int CLS_W  = $clog2(CLASSES),
    localparam int TAG_W  = ADDR_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CLS_W-1:0]  req_class,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              cfg_mask_we,
    input  logic [CLS_W-1:0]  cfg_mask_class,
    input  logic [WAYS-1:0]   cfg_mask_ways,
    input  logic              cfg_lock_we,
    input  logic [SET_W-1:0]  cfg_lock_set,
    input  logic [WAY_W-1:0]  cfg_lock_way,
    input  logic              cfg_lock_on
);

    import pcache_pkg::*;

    pc_state_e         state_q, state_d;
    logic              rq_write;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    logic [CLS_W-1:0]  rq_cls;
    logic [DATA_W-1:0] rsp_data_q;

    logic              accept;
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [DATA_W-1:0] lk_data;
    logic [WAYS-1:0]   lk_lock;
    logic [WAYS-1:0]   cls_mask;
    logic [WAYS-1:0]   allowed;
    logic [WAY_W-1:0]  vic_way;
    logic              vic_ok;
    logic              mem_done;
    logic              fill_en;
    logic              upd_en;

    assign accept   = req_valid && req_ready;
    assign lk_set   = rq_addr[SET_W-1:0];
    assign lk_tag   = rq_addr[ADDR_W-1:SET_W];
    assign allowed  = cls_mask & ~lk_lock;
    assign mem_done = (state_q == S_MEM) && mem_rsp_valid;
    assign fill_en  = mem_done && !rq_write && vic_ok;
    assign upd_en   = (state_q == S_LOOKUP) && rq_write && lk_hit;

    pcache_cfg #(
        .WAYS    (WAYS),
        .CLASSES (CLASSES),
        .CLS_W   (CLS_W)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_mask_we),
        .wr_cls  (cfg_mask_class),
        .wr_mask (cfg_mask_ways),
        .rd_cls  (rq_cls),
        .rd_mask (cls_mask)
    );

    pcache_tag_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .SET_W  (SET_W),
        .WAY_W  (WAY_W)
    ) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (lk_set),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .lk_data   (lk_data),
        .lk_lock   (lk_lock),
        .fill_en   (fill_en),
        .fill_way  (vic_way),
        .fill_tag  (lk_tag),
        .fill_data (mem_rsp_rdata),
        .upd_en    (upd_en),
        .upd_way   (lk_way),
        .upd_data  (rq_wdata),
        .lock_we   (cfg_lock_we),
        .lock_set  (cfg_lock_set),
        .lock_way  (cfg_lock_way),
        .lock_val  (cfg_lock_on)
    );

    pcache_victim #(
        .SETS    (SETS),
        .WAYS    (WAYS),
        .CLASSES (CLASSES),
        .SET_W   (SET_W),
        .WAY_W   (WAY_W),
        .CLS_W   (CLS_W)
    ) vic_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (lk_set),
        .cls_i     (rq_cls),
        .allowed_i (allowed),
        .adv_i     (fill_en),
        .vic_way_o (vic_way),
        .vic_ok_o  (vic_ok)
    );

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: hits finish in lookup, everything else goes to memory.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_LOOKUP;
            S_LOOKUP: state_d = (lk_hit && !rq_write) ? S_IDLE : S_MEM;
            S_MEM:    if (mem_rsp_valid) state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Capture the accepted request for the rest of its lifetime.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_write <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
            rq_cls   <= '0;
        end else if (accept) begin
            rq_write <= req_write;
            rq_addr  <= req_addr;
            rq_wdata <= req_wdata;
            rq_cls   <= req_class;
        end
    end

    // Keep the memory word for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data_q <= '0;
        end else if (mem_done) begin
            rsp_data_q <= mem_rsp_rdata;
        end
    end

    assign req_ready     = (state_q == S_IDLE);
    assign rsp_valid     = ((state_q == S_LOOKUP) && lk_hit && !rq_write) || (state_q == S_RESP);
    assign rsp_rdata     = (state_q == S_RESP) ? rsp_data_q : lk_data;
    assign mem_req_valid = (state_q == S_MEM);
    assign mem_req_write = rq_write;
    assign mem_req_addr  = rq_addr;
    assign mem_req_wdata = rq_wdata;

endmodule

// File: rtl/pcache_chk.sv
// Property checker for pcache_top, attached by bind below.
// Assumes: connected to the controller's ports and internal fill signals.
module pcache_chk #(
    parameter int ADDR_W = 12,
    parameter int WAYS   = 4,
    parameter int WAY_W  = $clog2(WAYS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              in_lookup,
    input logic              rq_write,
    input logic              lk_hit,
    input logic              fill_en,
    input logic [WAY_W-1:0]  fill_way,
    input logic [WAYS-1:0]   cls_mask,
    input logic [WAYS-1:0]   set_lock
);

    // R1: a read hit answers in lookup without touching memory.
    p_hit_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lookup && lk_hit && !rq_write) |-> (rsp_valid && !mem_req_valid));

    // R1: an accepted request makes the controller busy.
    p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: the response is a single-cycle pulse.
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3: fills stay inside the requesting class's mask.
    p_fill_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> cls_mask[fill_way]);

    // R6: a pinned way is never filled.
    p_no_lock_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !set_lock[fill_way]);

    // R8: writes never allocate.
    p_no_write_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !rq_write);

    // R10: memory request held steady until answered.
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

endmodule

bind pcache_top pcache_chk #(
    .ADDR_W (ADDR_W),
    .WAYS   (WAYS),
    .WAY_W  (WAY_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .in_lookup     (state_q == pcache_pkg::S_LOOKUP),
    .rq_write      (rq_write),
    .lk_hit        (lk_hit),
    .fill_en       (fill_en),
    .fill_way      (vic_way),
    .cls_mask      (cls_mask),
    .set_lock      (lk_lock)
);

// File: tb/pcache_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for pcache_top: one task per scenario, each self-checking.
module pcache_top_tb_top;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WAYS    = 4;
    localparam int SETS    = 4;
    localparam int CLASSES = 4;
    localparam int MEM_LAT = 3;
    localparam int HIT_LAT = 1;
    localparam int MISS_LAT = MEM_LAT + 2;

    logic              clk;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic [1:0]        req_class;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req_valid;
    logic              mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid;
    logic [DATA_W-1:0] mem_rsp_rdata;
    logic              cfg_mask_we;
    logic [1:0]        cfg_mask_class;
    logic [WAYS-1:0]   cfg_mask_ways;
    logic              cfg_lock_we;
    logic [1:0]        cfg_lock_set;
    logic [1:0]        cfg_lock_way;
    logic              cfg_lock_on;

    int checks = 0;
    int errors = 0;

    // Memory model bookkeeping.
    int                mem_cnt = 0;
    int                mem_txn = 0;
    int                hold_bad = 0;
    logic [ADDR_W-1:0] hold_addr = '0;
    logic              last_wr = 1'b0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [DATA_W-1:0] last_wdata = '0;

    pcache_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_class      (req_class),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .mem_req_valid  (mem_req_valid),
        .mem_req_write  (mem_req_write),
        .mem_req_addr   (mem_req_addr),
        .mem_req_wdata  (mem_req_wdata),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_rdata  (mem_rsp_rdata),
        .cfg_mask_we    (cfg_mask_we),
        .cfg_mask_class (cfg_mask_class),
        .cfg_mask_ways  (cfg_mask_ways),
        .cfg_lock_we    (cfg_lock_we),
        .cfg_lock_set   (cfg_lock_set),
        .cfg_lock_way   (cfg_lock_way),
        .cfg_lock_on    (cfg_lock_on)
    );

    // 200 MHz clock.
    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
        return (ADDR_W'(tag) << 2) | ADDR_W'(set);
    endfunction

    function automatic logic [DATA_W-1:0] memw(input logic [ADDR_W-1:0] a);
        return 32'hD000_0000 | DATA_W'(a);
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Memory: answers MEM_LAT cycles after the request appears.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
            end else if (mem_req_valid) begin
                if (mem_cnt == 0) hold_addr = mem_req_addr;
                else if (mem_req_addr != hold_addr) hold_bad++;
                mem_cnt++;
                if (mem_cnt == MEM_LAT) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = mem_req_write ? '0 : memw(mem_req_addr);
                    last_wr    = mem_req_write;
                    last_addr  = mem_req_addr;
                    last_wdata = mem_req_wdata;
                    mem_txn++;
                    mem_cnt = 0;
                end
            end
        end
    end

    // One request; checks latency, memory traffic and read data.
    task automatic do_req(input string rq, input logic wr, input int cls,
                          input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          input logic cached, input logic [DATA_W-1:0] exp_data);
        int t0;
        int lat;
        @(negedge clk);
        chk(rq, "ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        req_class = 2'(cls);
        t0 = mem_txn;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(rq, "latency", 32'(lat), cached ? 32'(HIT_LAT) : 32'(MISS_LAT));
        chk(rq, "memory transactions", 32'(mem_txn - t0), cached ? 32'd0 : 32'd1);
        if (!wr) chk(rq, "read data", rsp_rdata, exp_data);
        if (!cached) chk(rq, "memory address", {20'b0, last_addr}, {20'b0, a});
    endtask

    task automatic set_mask(input int cls, input logic [WAYS-1:0] m);
        @(negedge clk);
        cfg_mask_we = 1'b1; cfg_mask_class = 2'(cls); cfg_mask_ways = m;
        @(negedge clk);
        cfg_mask_we = 1'b0;
    endtask

    task automatic set_lock(input int set, input int way, input logic on);
        @(negedge clk);
        cfg_lock_we = 1'b1; cfg_lock_set = 2'(set); cfg_lock_way = 2'(way); cfg_lock_on = on;
        @(negedge clk);
        cfg_lock_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9", "req_ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R9", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        chk("R9", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_fill_hit();
        do_req("R9", 1'b0, 0, mk(1, 0), '0, 1'b0, memw(mk(1, 0)));
        do_req("R2", 1'b0, 0, mk(1, 0), '0, 1'b1, memw(mk(1, 0)));
        do_req("R4", 1'b0, 3, mk(1, 0), '0, 1'b1, memw(mk(1, 0)));
        do_req("R1", 1'b0, 1, mk(1, 0), '0, 1'b1, memw(mk(1, 0)));
    endtask

    task automatic t_fifo();
        for (int t = 1; t <= 4; t++) do_req("R5", 1'b0, 0, mk(t, 1), '0, 1'b0, memw(mk(t, 1)));
        do_req("R5", 1'b0, 0, mk(5, 1), '0, 1'b0, memw(mk(5, 1)));
        for (int t = 2; t <= 5; t++) do_req("R5", 1'b0, 0, mk(t, 1), '0, 1'b1, memw(mk(t, 1)));
        do_req("R5", 1'b0, 0, mk(1, 1), '0, 1'b0, memw(mk(1, 1)));
        do_req("R5", 1'b0, 0, mk(3, 1), '0, 1'b1, memw(mk(3, 1)));
    endtask

    task automatic t_partition();
        for (int t = 1; t <= 3; t++) do_req("R3", 1'b0, 0, mk(t, 2), '0, 1'b0, memw(mk(t, 2)));
        set_mask(1, 4'b1000);
        do_req("R3", 1'b0, 1, mk(8, 2), '0, 1'b0, memw(mk(8, 2)));
        do_req("R3", 1'b0, 1, mk(9, 2), '0, 1'b0, memw(mk(9, 2)));
        for (int t = 1; t <= 3; t++) do_req("R3", 1'b0, 0, mk(t, 2), '0, 1'b1, memw(mk(t, 2)));
        do_req("R3", 1'b0, 0, mk(9, 2), '0, 1'b1, memw(mk(9, 2)));
        do_req("R3", 1'b0, 1, mk(8, 2), '0, 1'b0, memw(mk(8, 2)));
    endtask

    task automatic t_lock();
        for (int t = 1; t <= 4; t++) do_req("R6", 1'b0, 0, mk(t, 3), '0, 1'b0, memw(mk(t, 3)));
        set_lock(3, 0, 1'b1);
        for (int t = 5; t <= 8; t++) do_req("R6", 1'b0, 0, mk(t, 3), '0, 1'b0, memw(mk(t, 3)));
        do_req("R6", 1'b0, 0, mk(1, 3), '0, 1'b1, memw(mk(1, 3)));
        set_lock(3, 0, 1'b0);
        for (int t = 9; t <= 11; t++) do_req("R6", 1'b0, 0, mk(t, 3), '0, 1'b0, memw(mk(t, 3)));
        do_req("R6", 1'b0, 0, mk(1, 3), '0, 1'b0, memw(mk(1, 3)));
    endtask

    task automatic t_bypass();
        set_mask(2, 4'b0010);
        set_lock(0, 1, 1'b1);
        do_req("R7", 1'b0, 2, mk(7, 0), '0, 1'b0, memw(mk(7, 0)));
        do_req("R7", 1'b0, 2, mk(7, 0), '0, 1'b0, memw(mk(7, 0)));
        do_req("R7", 1'b0, 0, mk(1, 0), '0, 1'b1, memw(mk(1, 0)));
        set_lock(0, 1, 1'b0);
    endtask

    task automatic t_write();
        do_req("R8", 1'b1, 0, mk(3, 1), 32'h1234_5678, 1'b0, '0);
        chk("R8", "write hit sent to memory", {31'b0, last_wr}, 32'd1);
        chk("R8", "write hit memory data", last_wdata, 32'h1234_5678);
        do_req("R8", 1'b0, 0, mk(3, 1), '0, 1'b1, 32'h1234_5678);
        do_req("R8", 1'b1, 0, mk(6, 1), 32'hCAFE_0006, 1'b0, '0);
        chk("R8", "write miss memory data", last_wdata, 32'hCAFE_0006);
        do_req("R8", 1'b0, 0, mk(6, 1), '0, 1'b0, memw(mk(6, 1)));
        chk("R10", "memory address changed while pending", 32'(hold_bad), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_class = '0;
        cfg_mask_we = 1'b0; cfg_mask_class = '0; cfg_mask_ways = '0;
        cfg_lock_we = 1'b0; cfg_lock_set = '0; cfg_lock_way = '0; cfg_lock_on = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_fifo();
        t_partition();
        t_lock();
        t_bypass();
        t_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule